// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a serial peripheral interface master that a processor drives through a small 32-bit register bus. Software loads outgoing words into a transmit queue, chooses a word length of 1 to 32 bits and one of four chip-select lines, and then sets a start bit. The block shifts one word out on the data-out line, most significant valid bit first, and shifts the data-in line into a receive queue at the same time.

The serial clock follows mode 0. It rests low, data-out changes while the clock is low, and data-in is sampled on each rising edge. Each half period of the serial clock lasts a parameter-set number of system clocks. The chip select can be held by software across several words, or the block can drive it only while a word is being shifted. Error and completion events latch in a status word, and software clears each one by writing a one to its bit.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, a status read (offset 0x08) returns only bit 23 (receive queue empty) and bit 21 (transmit queue empty) set. All four chip-select outputs are high and the serial clock is low.
- R2: When command bits [4:0] hold L, exactly L+1 rising clock edges occur. The low L+1 bits of the transmit entry appear on data-out, most significant first, stable while the clock is high. The clock rests low between words.
- R3: Data-in is sampled on each rising clock edge. When receive is enabled (command2 bit 31), the word is pushed into the receive queue right-justified, and a read of offset 0x180 returns it.
- R4: Command bit 30 starts a word only when bit 31 (enable) and bit 28 (master) are set and no word is in progress. It reads back as 0 once the word is accepted. With enable clear it stays pending and no clock edge occurs.
- R5: Status bit 31 (busy) is high while a word is shifting. Status bit 30 (ready) is set in the cycle busy falls and stays set.
- R6: Writing 1 to status bits 30, 25, 24, 19 or 18 clears that flag. Writing 0 leaves it unchanged, so writing back a value read from status clears every flag that was set.
- R7: A write to offset 0x100 while the transmit queue is full sets status bit 19 and drops the word.
- R8: A read of offset 0x180 while the receive queue is empty returns zero and sets status bit 18.
- R9: Starting a word with transmit enabled (command2 bit 30) and an empty transmit queue sets status bit 24, and the word shifts out as zeros.
- R10: Finishing a word with receive enabled and the receive queue full sets status bit 25 and drops the received word. Words already queued keep their order.
- R11: With command bit 11 set, chip select cs_n[idx] equals the inverse of command bit 12, where idx is command2 bits [19:18]. With bit 11 clear, cs_n[idx] is low only while busy. Unselected lines stay high.
- R12: Status bit 20 is set when the transmit queue is full and bit 22 when the receive queue is full. Status2 (offset 0x1C) holds the transmit level from bit 0 and the receive level from bit 16.
- R13: Command (0x00) and command2 (0x04) read back the fields written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read (pops the receive port) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sck | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
A corrupted shift register or bit counter shows at the serial pins within the same word. The slave model sees the wrong number of rising edges or the wrong data-out bits, and the word read from the receive port comes back misaligned. A broken queue pointer or level counter shows at the next status or status2 read as a wrong full or empty flag, or as a wrong order of received words. A sticky flag that is set or cleared wrongly is visible on the first status read after the event or the clearing write.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
   localparam int unsigned ADDR_W = 9;
   localparam logic [ADDR_W-1:0] A_CMD   = 9'h000;
   localparam logic [ADDR_W-1:0] A_CMD2  = 9'h004;
   localparam logic [ADDR_W-1:0] A_STAT  = 9'h008;
   localparam logic [ADDR_W-1:0] A_STAT2 = 9'h01C;
   localparam logic [ADDR_W-1:0] A_TXP   = 9'h100;
   localparam logic [ADDR_W-1:0] A_RXP   = 9'h180;
   // command fields
   localparam int B_EN = 31, B_GO = 30, B_MST = 28, B_CSVAL = 12, B_CSSW = 11;
   // command2 fields
   localparam int B2_RXEN = 31, B2_TXEN = 30, B2_SEL = 18;
   // status fields
   localparam int S_BSY = 31, S_RDY = 30, S_RXOVF = 25, S_TXUNR = 24;
   localparam int S_RXE = 23, S_RXF = 22, S_TXE = 21, S_TXF = 20;
   localparam int S_TXOVF = 19, S_RXUNR = 18;
   localparam int S2_RXLVL = 16;
   localparam int NUM_CS = 4;
   localparam int SEL_W  = 2;
endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [W-1:0]                   din,
   input  logic                           pop,
   output logic [W-1:0]                   dout,
   output logic                           full,
   output logic                           empty,
   output logic [$clog2(DEPTH+1)-1:0]     level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH+1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic [LVL_W-1:0] cnt;

   generate
      if ((DEPTH & (DEPTH-1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign full  = (cnt == LVL_W'(DEPTH));
   assign empty = (cnt == '0);
   assign level = cnt;

   p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full)
      else $error("push into full queue");
   p_pop_data_r8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty)
      else $error("pop from empty queue");
endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift #(
   parameter int W    = 32,
   parameter int HALF = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [$clog2(W)-1:0]  len,
   input  logic [W-1:0]          word,
   input  logic                  miso,
   output logic                  sck,
   output logic                  mosi,
   output logic                  busy,
   output logic                  done,
   output logic [W-1:0]          rx_word
);
   localparam int LEN_W = $clog2(W);
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CNT_W-1:0] cnt;
   logic [LEN_W:0]   left;
   logic [W-1:0]     tx_sh, rx_sh;
   logic             tick;

   assign tick    = busy && (cnt == CNT_W'(HALF-1));
   assign done    = tick && sck && (left == (LEN_W+1)'(1));
   assign mosi    = busy && tx_sh[W-1];
   assign rx_word = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sck   <= 1'b0;
         cnt   <= '0;
         left  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         sck   <= 1'b0;
         cnt   <= '0;
         left  <= {1'b0, len} + (LEN_W+1)'(1);
         tx_sh <= word << (LEN_W'(W-1) - len);
         rx_sh <= '0;
      end else if (busy) begin
         if (tick) begin
            cnt <= '0;
            sck <= ~sck;
            if (!sck) begin
               rx_sh <= {rx_sh[W-2:0], miso};
            end else if (done) begin
               busy <= 1'b0;
            end else begin
               left  <= left - 1'b1;
               tx_sh <= tx_sh << 1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_sck_rest_r2: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck)
      else $error("clock active while idle");
   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi))
      else $error("data-out moved while clock high");
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
   import spi_rm_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int SCK_HALF   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n
);
   localparam int WORD_W = 32;
   localparam int LEN_W  = $clog2(WORD_W);
   localparam int LVL_W  = $clog2(FIFO_DEPTH+1);

   generate
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 64) begin : g_bad_depth
         $error("FIFO_DEPTH must lie in 2..64");
      end
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
   endgenerate

   // register state
   logic             en_q, go_q, mst_q, cssw_q, csval_q, rxen_q, txen_q;
   logic [LEN_W-1:0] len_q;
   logic [SEL_W-1:0] sel_q;
   logic             rdy_q, rxovf_q, txunr_q, txovf_q, rxunr_q;

   // decode
   logic wr_cmd, wr_cmd2, wr_stat, wr_txp, rd_rxp;
   assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
   assign wr_cmd2 = bus_wr && (bus_addr == A_CMD2);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_txp  = bus_wr && (bus_addr == A_TXP);
   assign rd_rxp  = bus_rd && (bus_addr == A_RXP);

   logic unused_wbits;
   assign unused_wbits = ^bus_wdata;

   // queues and shifter
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [LVL_W-1:0]  tx_lvl, rx_lvl;
   logic              busy, done, start;

   assign start = go_q && en_q && mst_q && !busy;

   spi_rm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_txp && !tx_full), .din(bus_wdata),
      .pop(start && txen_q && !tx_empty), .dout(tx_head),
      .full(tx_full), .empty(tx_empty), .level(tx_lvl));

   spi_rm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(done && rxen_q && !rx_full), .din(rx_word),
      .pop(rd_rxp && !rx_empty), .dout(rx_head),
      .full(rx_full), .empty(rx_empty), .level(rx_lvl));

   spi_rm_shift #(.W(WORD_W), .HALF(SCK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .len(len_q),
      .word((txen_q && !tx_empty) ? tx_head : '0),
      .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .done(done),
      .rx_word(rx_word));

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; go_q <= 1'b0; mst_q <= 1'b0;
         cssw_q <= 1'b0; csval_q <= 1'b0; len_q <= '0;
         rxen_q <= 1'b0; txen_q <= 1'b0; sel_q <= '0;
      end else begin
         if (wr_cmd) begin
            en_q    <= bus_wdata[B_EN];
            go_q    <= bus_wdata[B_GO];
            mst_q   <= bus_wdata[B_MST];
            cssw_q  <= bus_wdata[B_CSSW];
            csval_q <= bus_wdata[B_CSVAL];
            len_q   <= bus_wdata[LEN_W-1:0];
         end else if (start) begin
            go_q <= 1'b0;
         end
         if (wr_cmd2) begin
            rxen_q <= bus_wdata[B2_RXEN];
            txen_q <= bus_wdata[B2_TXEN];
            sel_q  <= bus_wdata[B2_SEL +: SEL_W];
         end
      end
   end

   // sticky flags: a set event wins over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0; rxovf_q <= 1'b0; txunr_q <= 1'b0;
         txovf_q <= 1'b0; rxunr_q <= 1'b0;
      end else begin
         rdy_q   <= done | (rdy_q & ~(wr_stat & bus_wdata[S_RDY]));
         rxovf_q <= (done && rxen_q && rx_full) | (rxovf_q & ~(wr_stat & bus_wdata[S_RXOVF]));
         txunr_q <= (start && txen_q && tx_empty) | (txunr_q & ~(wr_stat & bus_wdata[S_TXUNR]));
         txovf_q <= (wr_txp && tx_full) | (txovf_q & ~(wr_stat & bus_wdata[S_TXOVF]));
         rxunr_q <= (rd_rxp && rx_empty) | (rxunr_q & ~(wr_stat & bus_wdata[S_RXUNR]));
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CMD: begin
            bus_rdata[B_EN]        = en_q;
            bus_rdata[B_GO]        = go_q;
            bus_rdata[B_MST]       = mst_q;
            bus_rdata[B_CSVAL]     = csval_q;
            bus_rdata[B_CSSW]      = cssw_q;
            bus_rdata[LEN_W-1:0]   = len_q;
         end
         A_CMD2: begin
            bus_rdata[B2_RXEN]         = rxen_q;
            bus_rdata[B2_TXEN]         = txen_q;
            bus_rdata[B2_SEL +: SEL_W] = sel_q;
         end
         A_STAT: begin
            bus_rdata[S_BSY]   = busy;
            bus_rdata[S_RDY]   = rdy_q;
            bus_rdata[S_RXOVF] = rxovf_q;
            bus_rdata[S_TXUNR] = txunr_q;
            bus_rdata[S_RXE]   = rx_empty;
            bus_rdata[S_RXF]   = rx_full;
            bus_rdata[S_TXE]   = tx_empty;
            bus_rdata[S_TXF]   = tx_full;
            bus_rdata[S_TXOVF] = txovf_q;
            bus_rdata[S_RXUNR] = rxunr_q;
         end
         A_STAT2: begin
            bus_rdata[LVL_W-1:0]         = tx_lvl;
            bus_rdata[S2_RXLVL +: LVL_W] = rx_lvl;
         end
         A_RXP:   bus_rdata = rx_empty ? '0 : rx_head;
         default: bus_rdata = '0;
      endcase
   end

   // chip-select decode
   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
         assign cs_n[i] = !((sel_q == SEL_W'(i)) && (cssw_q ? csval_q : busy));
      end
   endgenerate

   p_busy_ready_r5: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> rdy_q)
      else $error("ready not set at end of word");
   p_go_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !wr_cmd) |=> !go_q)
      else $error("start bit not cleared on acceptance");
   p_one_select_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n))
      else $error("more than one chip select active");
   p_txovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txp && tx_full) |=> txovf_q)
      else $error("transmit overflow not flagged");
   p_rxunr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxp && rx_empty) |=> rxunr_q)
      else $error("receive underrun not flagged");
endmodule

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int HALF       = 2;

   localparam logic [31:0] EN = 32'h8000_0000, GO = 32'h4000_0000, MST = 32'h1000_0000;
   localparam logic [31:0] CSVAL = 32'h0000_1000, CSSW = 32'h0000_0800;
   localparam logic [31:0] RXEN = 32'h8000_0000, TXEN = 32'h4000_0000;
   localparam logic [31:0] BSY = 32'h8000_0000, RDY = 32'h4000_0000;
   localparam logic [31:0] RXOVF = 32'h0200_0000, TXUNR = 32'h0100_0000;
   localparam logic [31:0] RXE = 32'h0080_0000, RXF = 32'h0040_0000;
   localparam logic [31:0] TXE = 32'h0020_0000, TXF = 32'h0010_0000;
   localparam logic [31:0] TXOVF = 32'h0008_0000, RXUNR = 32'h0004_0000;
   localparam logic [8:0]  A_CMD = 9'h000, A_CMD2 = 9'h004, A_STAT = 9'h008;
   localparam logic [8:0]  A_STAT2 = 9'h01C, A_TXP = 9'h100, A_RXP = 9'h180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0, rdata;
   logic        sck, mosi, miso;
   logic [3:0]  cs_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_regmaster #(.FIFO_DEPTH(DEPTH), .SCK_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi),
      .miso(miso), .cs_n(cs_n));

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // slave model: presents bits MSB first before each rising edge, captures data-out
   logic [31:0] slv_tx = '0, slv_rx;
   int          slv_n = 0, edge_cnt;
   logic        slv_clr = 1'b0;

   always_comb begin
      if (slv_n > 0 && edge_cnt < slv_n) miso = slv_tx[slv_n-1-edge_cnt];
      else miso = 1'b0;
   end

   always @(posedge sck or posedge slv_clr) begin
      if (slv_clr) begin
         edge_cnt <= 0;
         slv_rx   <= '0;
      end else begin
         edge_cnt <= edge_cnt + 1;
         slv_rx   <= {slv_rx[30:0], mosi};
      end
   end

   task automatic slave_set(input logic [31:0] w, input int n);
      slv_tx = w;
      slv_n  = n;
      slv_clr = 1'b1;
      #1 slv_clr = 1'b0;
   endtask

   task automatic bw(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic br(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #(CLK_PERIOD/4);
      d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic wait_rdy();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         br(A_STAT, s);
         if (s & RDY) begin
            chk("R5 busy low when ready", s & BSY, 32'h0);
            return;
         end
      end
      chk("R5 ready never set", s & RDY, RDY);
   endtask

   function automatic logic [31:0] lmask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, txw, sw, cmdv;
      logic [31:0] qw [DEPTH];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      br(A_STAT, v);
      chk("R1 status after reset", v, RXE | TXE);
      chk("R1 chip selects", {28'h0, cs_n}, 32'hF);
      chk("R1 clock rest", {31'h0, sck}, 32'h0);
      br(A_STAT2, v);
      chk("R12 levels after reset", v, 32'h0);

      // R13 readback
      bw(A_CMD2, RXEN | TXEN | (32'd2 << 18));
      br(A_CMD2, v);
      chk("R13 command2 readback", v, RXEN | TXEN | (32'd2 << 18));

      // R2 R3 R11 sweep of lengths and select indices
      for (int n = 1; n <= 32; n++) begin
         int idx = n % 4;
         txw  = 32'hA5C3_0F96 ^ (32'h0101_0101 * 32'(n));
         sw   = {txw[15:0], ~txw[31:16]} ^ 32'(n * 7);
         bw(A_CMD2, RXEN | TXEN | (32'(idx) << 18));
         slave_set(sw, n);
         bw(A_TXP, txw);
         cmdv = EN | GO | MST | CSSW | CSVAL | 32'(n - 1);
         bw(A_CMD, cmdv);
         if (n >= 8) begin
            br(A_STAT, v);
            chk("R5 busy during word", v & BSY, BSY);
         end
         wait_rdy();
         chk("R2 data-out bits", slv_rx, txw & lmask(n));
         chk("R2 rising edge count", 32'(edge_cnt), 32'(n));
         chk("R11 software select", {28'h0, cs_n}, {28'h0, ~(4'b0001 << idx)});
         br(A_RXP, v);
         chk("R3 received word", v, sw & lmask(n));
         br(A_CMD, v);
         chk("R4 start bit reads 0 after accept", v, cmdv & ~GO);
         bw(A_STAT, RDY);
         br(A_STAT, v);
         chk("R6 ready cleared", v & RDY, 32'h0);
      end

      // R11 release
      bw(A_CMD, EN | MST | CSSW);
      chk("R11 software release", {28'h0, cs_n}, 32'hF);

      // R4 start with enable clear
      bw(A_CMD2, RXEN | TXEN);
      slave_set(32'h0, 8);
      bw(A_CMD, GO | MST | CSSW | 32'd7);
      repeat (40) @(negedge clk);
      br(A_STAT, v);
      chk("R4 disabled: no busy or ready", v & (BSY | RDY), 32'h0);
      chk("R4 disabled: no clock edges", 32'(edge_cnt), 32'h0);
      br(A_CMD, v);
      chk("R4 disabled: start pending", v & GO, GO);
      bw(A_CMD, 32'h0);

      // R11 hardware select on index 3
      bw(A_CMD2, RXEN | TXEN | (32'd3 << 18));
      slave_set(32'h0000_C3A5, 16);
      bw(A_TXP, 32'h0000_1234);
      bw(A_CMD, EN | GO | MST | 32'd15);
      br(A_STAT, v);
      chk("R11 hardware select while busy", {28'h0, cs_n}, 32'h7);
      wait_rdy();
      chk("R11 hardware select after word", {28'h0, cs_n}, 32'hF);
      br(A_RXP, v);
      chk("R3 received word 16 bits", v, 32'h0000_C3A5);
      bw(A_STAT, RDY);

      // R7 R12 fill transmit queue
      bw(A_CMD2, RXEN | TXEN);
      for (int k = 0; k < DEPTH; k++) begin
         qw[k] = 32'h0000_0100 * 32'(k + 1) + 32'h5A + 32'(k);
         bw(A_TXP, qw[k]);
      end
      br(A_STAT, v);
      chk("R12 transmit full flag", v & (TXF | TXE), TXF);
      chk("R7 no overflow before extra write", v & TXOVF, 32'h0);
      br(A_STAT2, v);
      chk("R12 transmit level", v & 32'hFFFF, 32'(DEPTH));
      bw(A_TXP, 32'hDEAD_BEEF);
      br(A_STAT, v);
      chk("R7 overflow flag", v & TXOVF, TXOVF);

      // R9 R10 five words into a queue of four
      for (int k = 0; k <= DEPTH; k++) begin
         slave_set(32'h20 + 32'(k * 17), 8);
         bw(A_CMD, EN | GO | MST | CSSW | CSVAL | 32'd7);
         wait_rdy();
         chk(k < DEPTH ? "R2 queued byte out" : "R9 underrun shifts zeros",
             slv_rx, (k < DEPTH) ? (qw[k] & 32'hFF) : 32'h0);
         bw(A_STAT, RDY);
      end
      br(A_STAT, v);
      chk("R9 underrun flag", v & TXUNR, TXUNR);
      chk("R10 overflow flag", v & RXOVF, RXOVF);
      chk("R12 receive full flag", v & (RXF | RXE), RXF);
      br(A_STAT2, v);
      chk("R12 receive level", v >> 16, 32'(DEPTH));
      for (int k = 0; k < DEPTH; k++) begin
         br(A_RXP, v);
         chk("R10 queued order kept", v, 32'h20 + 32'(k * 17));
      end
      br(A_STAT, v);
      chk("R8 no underrun yet", v & RXUNR, 32'h0);
      br(A_RXP, v);
      chk("R8 empty read returns zero", v, 32'h0);
      br(A_STAT, v);
      chk("R8 underrun flag", v & RXUNR, RXUNR);

      // R6 write-zero keeps, write-back clears
      bw(A_STAT, 32'h0);
      br(A_STAT, v);
      chk("R6 zero write keeps flags", v & (RXOVF | TXUNR | TXOVF | RXUNR),
          RXOVF | TXUNR | TXOVF | RXUNR);
      bw(A_STAT, v);
      br(A_STAT, v);
      chk("R6 write-back clears all", v, RXE | TXE);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule